// File: doc/BRIEF.md
# Strobed Serial Register Slave

This block sits on the device side of a four-wire serial link made of a serial clock, a data-in line, a data-out line and an active-low strobe. Through this link a host reaches a small bank of 32-bit registers. The block samples all serial lines with its own fast system clock, finds the serial clock edges there, and keeps a running history of the last 40 data-in bits. Frames are delimited by bit position. The strobe marks only the final clock pulse, and that pulse carries a direction bit.

When the strobe is low on a rising serial edge, a direction bit of 1 commits the 32-bit value and 8-bit address held in the history. A direction bit of 0 loads the contents of the addressed register into an output shifter. The host then clocks 32 more pulses to collect that value on data-out. The bank holds two read/write settings registers, a read-only switch register fed by an external bus, a read-only version constant, and a reset-control register. Writing 1 to the reset-control register raises a system reset request for a fixed number of system clocks. The system clock must run at least four times faster than the serial clock.

Top module: `serial_regbank_slave`

## Requirements
- R1: A write frame is 32 data bits and then 8 address bits, both MSB first and sampled on rising serial clock edges, followed by one pulse with data-in 1 and the strobe low. That frame stores the data at address 0x00 (shown on mode_out) or at address 0x02 (shown on mux_out).
- R2: A read frame is 8 address bits and then one pulse with data-in 0 and the strobe low, followed by 32 more pulses. The addressed value is placed on ser_dout MSB first. The first bit appears after the falling edge of the strobe pulse, and each later bit appears after the next serial falling edge.
- R3: Address 0x08 reads the synchronised sw_in bus, zero-extended to 32 bits. Address 0xFF reads the VERSION parameter.
- R4: Writes to 0x08, to 0xFF, or to any address outside {0x00, 0x02, 0x08, 0x80, 0xFF} change no register.
- R5: A read of an unmapped address returns 0xFFFFFFFF. ser_dout is 1 when idle, including after the 32nd bit of a read.
- R6: Writing exactly 1 to address 0x80 raises rst_req for exactly RST_CYCLES system clocks. The register then reads 0. A second write of 1 during the pulse does not lengthen it.
- R7: Writing any other value to 0x80 stores it for read-back and leaves rst_req low.
- R8: After reset, ser_dout is 1, rst_req is 0, and mode_out and mux_out are 0. The first transaction after reset, a read of the version register, completes correctly.
- R9: ser_dout changes only in the system clock cycle after a detected serial falling edge.
- R10: Clock pulses while the strobe is high only shift the history and never commit a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial clock from host |
| ser_din | input | 1 | Serial data from host |
| ser_stb_n | input | 1 | Active-low strobe from host |
| ser_dout | output | 1 | Serial read data to host |
| sw_in | input | SW_W | External switch inputs (asynchronous) |
| mode_out | output | DATA_W | Mode settings register |
| mux_out | output | DATA_W | Multiplexer settings register |
| rst_req | output | 1 | System reset request pulse |

## Verification
The checker examines a set of rules on every cycle. The settings outputs may change only in the cycle after a write strobe to their own address. A reset request may start only after a write of 1 to the reset-control address, and it never lasts longer than RST_CYCLES. The data-out line may move only right after a serial falling edge. The directed scenarios cover the rest: the bit order of whole frames, the value read back from every address, writes ignored at read-only and unmapped addresses, frames without a strobe, and the exact pulse length.

// File: rtl/srs_pkg.sv
package srs_pkg;
    localparam int ADDR_W_DEF = 8;
    localparam int DATA_W_DEF = 32;
    localparam logic [7:0] A_MODE  = 8'h00;
    localparam logic [7:0] A_MUX   = 8'h02;
    localparam logic [7:0] A_SW    = 8'h08;
    localparam logic [7:0] A_RCTL  = 8'h80;
    localparam logic [7:0] A_VER   = 8'hFF;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = d_in;
        for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= {STAGES{RST_VAL}};
        else        stage_q <= stage_d;
    end

    assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/srs_frame.sv
module srs_frame #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    localparam int HIST_W = DATA_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              din_s,
    input  logic              stb_n_s,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata,
    output logic              wr_stb,
    output logic              fall_evt,
    output logic              dout
);
    typedef struct packed {
        logic              sclk_prev;
        logic [HIST_W-1:0] hist;
        logic [DATA_W-1:0] osh;
        logic              dout;
    } frame_t;

    frame_t st_d, st_q;
    logic   rise_evt;

    always_comb begin
        st_d     = st_q;
        wr_stb   = 1'b0;
        rise_evt = sclk_s & ~st_q.sclk_prev;
        fall_evt = ~sclk_s & st_q.sclk_prev;
        st_d.sclk_prev = sclk_s;
        if (rise_evt) begin
            if (!stb_n_s) begin
                if (din_s) wr_stb   = 1'b1;
                else       st_d.osh = rdata;
            end else begin
                st_d.hist = {st_q.hist[HIST_W-2:0], din_s};
            end
        end
        if (fall_evt) begin
            st_d.dout = st_q.osh[DATA_W-1];
            st_d.osh  = {st_q.osh[DATA_W-2:0], 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sclk_prev <= 1'b0;
            st_q.hist      <= '0;
            st_q.osh       <= '1;
            st_q.dout      <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_addr  = st_q.hist[ADDR_W-1:0];
    assign cmd_wdata = st_q.hist[HIST_W-1:ADDR_W];
    assign dout      = st_q.dout;
endmodule

// File: rtl/srs_regs.sv
module srs_regs #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int SW_W = 8,
    parameter logic [DATA_W-1:0] VERSION = '0,
    parameter int RST_CYCLES = 16,
    localparam int CNT_W = $clog2(RST_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SW_W-1:0]   sw_s,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] mode_q_o,
    output logic [DATA_W-1:0] mux_q_o,
    output logic              rst_req
);
    import srs_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] mode;
        logic [DATA_W-1:0] mux;
        logic [DATA_W-1:0] rctl;
        logic [CNT_W-1:0]  cnt;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (rg_q.cnt != '0) begin
            rg_d.cnt = rg_q.cnt - 1'b1;
            if (rg_q.cnt == CNT_W'(1)) rg_d.rctl = '0;
        end
        if (wr_stb) begin
            if (addr == ADDR_W'(A_MODE)) rg_d.mode = wdata;
            if (addr == ADDR_W'(A_MUX))  rg_d.mux  = wdata;
            if (addr == ADDR_W'(A_RCTL)) begin
                rg_d.rctl = wdata;
                if (wdata == DATA_W'(1) && rg_q.cnt == '0)
                    rg_d.cnt = CNT_W'(RST_CYCLES);
            end
        end
    end

    always_comb begin
        if      (addr == ADDR_W'(A_MODE)) rdata = rg_q.mode;
        else if (addr == ADDR_W'(A_MUX))  rdata = rg_q.mux;
        else if (addr == ADDR_W'(A_SW))   rdata = DATA_W'(sw_s);
        else if (addr == ADDR_W'(A_RCTL)) rdata = rg_q.rctl;
        else if (addr == ADDR_W'(A_VER))  rdata = VERSION;
        else                              rdata = '1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign mode_q_o = rg_q.mode;
    assign mux_q_o  = rg_q.mux;
    assign rst_req  = (rg_q.cnt != '0);
endmodule

// File: rtl/serial_regbank_slave.sv
module serial_regbank_slave #(
    parameter int DATA_W = srs_pkg::DATA_W_DEF,
    parameter int ADDR_W = srs_pkg::ADDR_W_DEF,
    parameter int SW_W = 8,
    parameter int SYNC_STAGES = 2,
    parameter int RST_CYCLES = 16,
    parameter logic [DATA_W-1:0] VERSION = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              ser_stb_n,
    output logic              ser_dout,
    input  logic [SW_W-1:0]   sw_in,
    output logic [DATA_W-1:0] mode_out,
    output logic [DATA_W-1:0] mux_out,
    output logic              rst_req
);
    logic [2:0]        line_s;
    logic [SW_W-1:0]   sw_s;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_wdata, rdata;
    logic              wr_stb, fall_evt;

    srs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync_line (
        .clk(clk), .rst_n(rst_n),
        .d_in({ser_clk, ser_din, ser_stb_n}), .q_out(line_s)
    );

    srs_sync #(.W(SW_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_sw (
        .clk(clk), .rst_n(rst_n), .d_in(sw_in), .q_out(sw_s)
    );

    srs_frame #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(line_s[2]), .din_s(line_s[1]), .stb_n_s(line_s[0]),
        .rdata(rdata), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .wr_stb(wr_stb), .fall_evt(fall_evt), .dout(ser_dout)
    );

    srs_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SW_W(SW_W),
               .VERSION(VERSION), .RST_CYCLES(RST_CYCLES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(cmd_addr),
        .wdata(cmd_wdata), .sw_s(sw_s), .rdata(rdata),
        .mode_q_o(mode_out), .mux_q_o(mux_out), .rst_req(rst_req)
    );
endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int RST_CYCLES = 16,
    localparam int CW = $clog2(RST_CYCLES + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_dout,
    input logic              rst_req,
    input logic [DATA_W-1:0] mode_out,
    input logic [DATA_W-1:0] mux_out,
    input logic              fall_evt,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [DATA_W-1:0] cmd_wdata
);
    import srs_pkg::*;

    logic [CW-1:0] high_run;
    always_ff @(posedge clk) begin
        if (!rst_n)       high_run <= '0;
        else if (rst_req) high_run <= high_run + 1'b1;
        else              high_run <= '0;
    end

    assert_mode_on_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_out) |-> $past(wr_stb && cmd_addr == ADDR_W'(A_MODE)));

    assert_mux_on_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mux_out) |-> $past(wr_stb && cmd_addr == ADDR_W'(A_MUX)));

    assert_req_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(wr_stb && cmd_addr == ADDR_W'(A_RCTL)
                                 && cmd_wdata == DATA_W'(1)));

    assert_req_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (high_run < CW'(RST_CYCLES)));

    assert_dout_after_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_dout) |-> $past(fall_evt));
endmodule

bind serial_regbank_slave srs_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ser_dout(ser_dout), .rst_req(rst_req),
    .mode_out(mode_out), .mux_out(mux_out), .fall_evt(fall_evt),
    .wr_stb(wr_stb), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata)
);

// File: tb/tb_serial_regbank_slave.sv
module tb_serial_regbank_slave;
    localparam int HALF = 6;
    localparam int RSTC = 10;
    localparam logic [31:0] VER = 32'hC0DE_0042;

    logic clk = 0, rst_n = 0;
    logic ser_clk = 0, ser_din = 0, ser_stb_n = 1;
    logic ser_dout, rst_req;
    logic [7:0] sw_in = 8'hA5;
    logic [31:0] mode_out, mux_out;
    int checks = 0, errors = 0;
    int run = 0, last_run = 0, pulses = 0;
    bit done = 0;

    always #10 clk = ~clk;

    serial_regbank_slave #(.SW_W(8), .RST_CYCLES(RSTC), .VERSION(VER)) dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .ser_stb_n(ser_stb_n), .ser_dout(ser_dout), .sw_in(sw_in),
        .mode_out(mode_out), .mux_out(mux_out), .rst_req(rst_req)
    );

    always @(negedge clk) begin
        if (rst_req) run++;
        else if (run != 0) begin last_run = run; run = 0; pulses++; end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        waitc(HALF); ser_clk = 1; waitc(HALF); ser_clk = 0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin ser_din = v[i]; pulse(); end
    endtask

    task automatic strobe(input logic dir);
        ser_din = dir; ser_stb_n = 0; pulse(); waitc(HALF); ser_stb_n = 1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        send(d, 32); send({24'h0, a}, 8); strobe(1'b1); waitc(4);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        send({24'h0, a}, 8); strobe(1'b0);
        for (int i = 31; i >= 0; i--) begin
            waitc(HALF); ser_clk = 1; waitc(2); d[i] = ser_dout;
            waitc(HALF - 2); ser_clk = 0;
        end
        waitc(HALF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R8 dout idle", 32'(ser_dout), 32'd1);
        chk("R8 rst_req low", 32'(rst_req), 32'd0);
        chk("R8 mode zero", mode_out, 32'h0);
        chk("R8 mux zero", mux_out, 32'h0);
        rd(8'hFF, v);
        chk("R8 R3 first version read", v, VER);
        chk("R5 dout idle after read", 32'(ser_dout), 32'd1);
    endtask

    task automatic t_rw();
        logic [31:0] v;
        wr(8'h00, 32'h8000_0001);
        chk("R1 mode_out", mode_out, 32'h8000_0001);
        wr(8'h02, 32'h3C5A_F00F);
        chk("R1 mux_out", mux_out, 32'h3C5A_F00F);
        rd(8'h00, v); chk("R2 mode readback", v, 32'h8000_0001);
        rd(8'h02, v); chk("R2 mux readback", v, 32'h3C5A_F00F);
        rd(8'h08, v); chk("R3 switch read", v, 32'h0000_00A5);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        wr(8'hFF, 32'h1111_2222);
        wr(8'h08, 32'h3333_4444);
        wr(8'h33, 32'h5555_6666);
        chk("R4 mode kept", mode_out, 32'h8000_0001);
        chk("R4 mux kept", mux_out, 32'h3C5A_F00F);
        rd(8'hFF, v); chk("R4 version kept", v, VER);
        rd(8'h08, v); chk("R4 switch kept", v, 32'h0000_00A5);
        rd(8'h33, v); chk("R5 unmapped read", v, 32'hFFFF_FFFF);
        chk("R10 no rst_req", 32'(pulses), 32'd0);
    endtask

    task automatic t_no_strobe();
        send(32'hDEAD_BEEF, 32); send(32'h0, 8); ser_din = 1; pulse(); waitc(4);
        chk("R10 mode unchanged", mode_out, 32'h8000_0001);
    endtask

    task automatic t_reset_pulse();
        logic [31:0] v;
        wr(8'h80, 32'h0000_0001);
        waitc(RSTC + 4);
        chk("R6 pulse count", 32'(pulses), 32'd1);
        chk("R6 pulse length", 32'(last_run), 32'(RSTC));
        rd(8'h80, v); chk("R6 rctl cleared", v, 32'h0);
    endtask

    task automatic t_rctl_other();
        logic [31:0] v;
        wr(8'h80, 32'h0000_0005);
        waitc(RSTC + 4);
        chk("R7 no pulse", 32'(pulses), 32'd1);
        rd(8'h80, v); chk("R7 rctl stored", v, 32'h0000_0005);
    endtask

    initial begin
        waitc(5); rst_n = 1; waitc(5);
        t_reset();
        t_rw();
        t_readonly();
        t_no_strobe();
        t_reset_pulse();
        t_rctl_other();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule